// File: doc/BRIEF.md
# Memory-Mapped Event Counter Bank

The block is a bank of event-counting slots that software programs and reads over a simple register bus. Every slot has a 64-bit control word, a primary 64-bit counter and an extended 64-bit counter. Both counters share the slot's control word and advance in step, so a latency measurement can add delay cycles in the primary counter while it counts packets in the extended one. Traffic monitors outside the bank drive one pulse vector for primary increments and one for extended increments, with one line per event. They also present the target identifier and the length class of the traffic in that cycle. The slot's event code picks one line, and optional target and threshold filters qualify it.

A global gate bit stops every slot at once. Writing the slot's reset bit zeroes both of its counters. Software normally preloads a counter with bit 63 set, so the counter wraps after 2^63 increments. A wrap of either counter latches a sticky per-slot status bit, and software clears that bit by writing a one to it. A per-slot mask decides whether the status bit drives the bank's single level interrupt output. Register reads are combinational and have no side effects. Writes take effect at the next clock edge.

Top module: `pcb_bank`

## Requirements
- R1: After reset the global control reads 0. Every control word reads 0x4_0000_0000 (bit 34 alone). Every counter reads 0, every interrupt mask reads 1, every status reads 0, and `irq` is low.
- R2: Slot i's registers sit at a base plus 8*i. The control base is 0x010, the primary counter base 0x090, the extended counter base 0x110, the status base 0x150 and the mask base 0x154. The global control is at 0x000. Offsets 0xFE0, 0xFE4 and 0xFE8 return the parameters RANGE_INFO, VERSION and IDENT_INFO. Any other offset, such as 0x0D0 or 0x800, reads zero.
- R3: A slot's primary (extended) counter goes up by one in each cycle where four things hold: global bit 0 is 1, control bit 20 is 1, control bits 15:0 equal an event line index n below NEV, and `pri_inc[n]` (`ext_inc[n]`) is high. No other line counts.
- R4: While global control bit 0 is 0, no slot counts, whatever its own enable.
- R5: When control bit 32 is set, the slot counts only in cycles where `ev_target` equals control bits 52:36.
- R6: When control bit 26 is set, the slot counts only in cycles where the threshold test passes. The threshold length is control bits 31:28. With bit 27 at 0 the test is `ev_len` >= the length, and with bit 27 at 1 it is `ev_len` < the length. A threshold length above 10 is invalid and leaves the test disabled.
- R7: A control write with bit 22 set zeroes both counters of that slot at that edge. The control word stores every other written bit, and bit 22 always reads back 0.
- R8: Both counters are writable 64-bit registers. A software write to a counter takes precedence over an increment in the same cycle.
- R9: An increment that takes either counter from all-ones to zero sets status bit 0 of the slot, and the bit stays set. Writing status bit 0 = 1 clears it and writing 0 leaves it unchanged. A wrap wins over a clear in the same cycle.
- R10: `irq` is high while any slot has status 1 and mask 0, where mask bit 0 = 1 masks the slot. It stays high until every such status is cleared or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 64 | Write data (32-bit registers take the low bits) |
| bus_rdata | output | 64 | Combinational read data for bus_addr |
| pri_inc | input | NEV | Primary increment pulse, one line per event |
| ext_inc | input | NEV | Extended increment pulse, one line per event |
| ev_target | input | 17 | Target identifier of the current traffic |
| ev_len | input | 4 | Length class of the current traffic |
| irq | output | 1 | Level interrupt from unmasked overflow status |

## Verification
The counting path gets several input patterns. Equal pulse trains on both vectors show that the two counters advance together. A primary-only train shows they are independent. Pulses on a neighbouring line, or a mismatched event code, show that the line select holds. Traffic with a matching and a non-matching target tells the target compare apart from plain counting. Lengths on each side of the threshold, in both modes, expose a swapped or off-by-one comparison. An over-limit length shows that the limit rule disables the filter. Preloads just below the wrap point, on each counter, exercise the status and interrupt path through mask, write-zero and write-one-to-clear. A counter write landing during a pulse train shows that the write wins.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  localparam int ADDR_W      = 12;
  localparam int DATA_W      = 64;
  localparam int SLOT_STRIDE = 8;

  localparam logic [ADDR_W-1:0] OFF_GLB   = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_PRI   = 12'h090;
  localparam logic [ADDR_W-1:0] OFF_EXT   = 12'h110;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h150;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h154;
  localparam logic [ADDR_W-1:0] OFF_RANGE = 12'hFE0;
  localparam logic [ADDR_W-1:0] OFF_VER   = 12'hFE4;
  localparam logic [ADDR_W-1:0] OFF_IDENT = 12'hFE8;

  // control word fields
  localparam int CODE_LO    = 0;
  localparam int CODE_W     = 16;
  localparam int B_EN       = 20;
  localparam int B_CLR      = 22;
  localparam int B_THR_EN   = 26;
  localparam int B_THR_MODE = 27;
  localparam int THR_LO     = 28;
  localparam int LEN_W      = 4;
  localparam int B_TGT_EN   = 32;
  localparam int TGT_LO     = 36;
  localparam int TGT_W      = 17;
  localparam int THR_LIMIT  = 10;

  localparam logic [DATA_W-1:0] CTRL_IDLE = 64'h0000_0004_0000_0000;

  typedef enum logic [3:0] {
    K_NONE, K_GLB, K_CTRL, K_PRI, K_EXT, K_STAT, K_MASK, K_RANGE, K_VER, K_IDENT
  } reg_kind_e;

  // address falls in a per-slot bank starting at base
  function automatic logic in_bank(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] base, int n);
    logic [ADDR_W:0] lim;
    lim = {1'b0, base} + (ADDR_W+1)'(SLOT_STRIDE * n);
    return ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < lim) && (a[2:0] == base[2:0]);
  endfunction

  // threshold qualifier on the length class of the traffic
  function automatic logic thr_pass(logic en, logic mode, logic [LEN_W-1:0] thr,
                                    logic [LEN_W-1:0] len);
    if (!en) return 1'b1;
    if (thr > LEN_W'(THR_LIMIT)) return 1'b1;
    if (mode) return len < thr;
    return len >= thr;
  endfunction

  function automatic logic tgt_pass(logic en, logic [TGT_W-1:0] want, logic [TGT_W-1:0] got);
    return !en || (want == got);
  endfunction

  // value kept in the control word: the reset bit never sticks
  function automatic logic [DATA_W-1:0] ctrl_store(logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] v;
    v = w;
    v[B_CLR] = 1'b0;
    return v;
  endfunction

  // increment with carry out; the carry marks a wrap
  function automatic logic [DATA_W:0] bump(logic [DATA_W-1:0] c);
    return {1'b0, c} + (DATA_W+1)'(1);
  endfunction

endpackage

// File: rtl/pcb_decode.sv
module pcb_decode
  import pcb_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int SLOT_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [SLOT_W-1:0] slot
);

  logic [ADDR_W-1:0] off;

  always_comb begin
    kind = K_NONE;
    off  = '0;
    if (addr == OFF_GLB) begin
      kind = K_GLB;
    end else if (in_bank(addr, OFF_CTRL, NSLOT)) begin
      kind = K_CTRL;
      off  = addr - OFF_CTRL;
    end else if (in_bank(addr, OFF_PRI, NSLOT)) begin
      kind = K_PRI;
      off  = addr - OFF_PRI;
    end else if (in_bank(addr, OFF_EXT, NSLOT)) begin
      kind = K_EXT;
      off  = addr - OFF_EXT;
    end else if (in_bank(addr, OFF_STAT, NSLOT)) begin
      kind = K_STAT;
      off  = addr - OFF_STAT;
    end else if (in_bank(addr, OFF_MASK, NSLOT)) begin
      kind = K_MASK;
      off  = addr - OFF_MASK;
    end else if (addr == OFF_RANGE) begin
      kind = K_RANGE;
    end else if (addr == OFF_VER) begin
      kind = K_VER;
    end else if (addr == OFF_IDENT) begin
      kind = K_IDENT;
    end
    slot = SLOT_W'(off >> 3);
  end

endmodule

// File: rtl/pcb_filter.sv
module pcb_filter
  import pcb_pkg::*;
#(
  parameter int NEV = 16
) (
  input  logic              glb_en,
  input  logic              slot_en,
  input  logic [CODE_W-1:0] code,
  input  logic              tgt_en,
  input  logic [TGT_W-1:0]  tgt_want,
  input  logic              thr_en,
  input  logic              thr_mode,
  input  logic [LEN_W-1:0]  thr_len,
  input  logic [NEV-1:0]    pri_inc,
  input  logic [NEV-1:0]    ext_inc,
  input  logic [TGT_W-1:0]  ev_target,
  input  logic [LEN_W-1:0]  ev_len,
  output logic              pri_step,
  output logic              ext_step
);

  localparam int LINE_W = (NEV > 1) ? $clog2(NEV) : 1;

  logic              code_ok;
  logic              gate;
  logic [LINE_W-1:0] line;

  assign code_ok  = code < CODE_W'(NEV);
  assign line     = code[LINE_W-1:0];
  assign gate     = glb_en && slot_en && code_ok &&
                    tgt_pass(tgt_en, tgt_want, ev_target) &&
                    thr_pass(thr_en, thr_mode, thr_len, ev_len);
  assign pri_step = gate && pri_inc[line];
  assign ext_step = gate && ext_inc[line];

endmodule

// File: rtl/pcb_slot.sv
module pcb_slot
  import pcb_pkg::*;
#(
  parameter int NEV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              wr_ctrl,
  input  logic              wr_pri,
  input  logic              wr_ext,
  input  logic              wr_stat,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NEV-1:0]    pri_inc,
  input  logic [NEV-1:0]    ext_inc,
  input  logic [TGT_W-1:0]  ev_target,
  input  logic [LEN_W-1:0]  ev_len,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] pri_q,
  output logic [DATA_W-1:0] ext_q,
  output logic              stat_q,
  output logic              mask_q,
  output logic              slot_en,
  output logic              pri_step,
  output logic              ext_step,
  output logic              wrap
);

  logic            clr;
  logic [DATA_W:0] pri_nxt;
  logic [DATA_W:0] ext_nxt;
  logic            pri_wrap;
  logic            ext_wrap;

  assign slot_en = ctrl_q[B_EN];

  pcb_filter #(.NEV(NEV)) u_flt (
    .glb_en    (glb_en),
    .slot_en   (slot_en),
    .code      (ctrl_q[CODE_LO +: CODE_W]),
    .tgt_en    (ctrl_q[B_TGT_EN]),
    .tgt_want  (ctrl_q[TGT_LO +: TGT_W]),
    .thr_en    (ctrl_q[B_THR_EN]),
    .thr_mode  (ctrl_q[B_THR_MODE]),
    .thr_len   (ctrl_q[THR_LO +: LEN_W]),
    .pri_inc   (pri_inc),
    .ext_inc   (ext_inc),
    .ev_target (ev_target),
    .ev_len    (ev_len),
    .pri_step  (pri_step),
    .ext_step  (ext_step)
  );

  assign clr      = wr_ctrl && wdata[B_CLR];
  assign pri_nxt  = bump(pri_q);
  assign ext_nxt  = bump(ext_q);
  assign pri_wrap = pri_step && pri_nxt[DATA_W] && !wr_pri && !clr;
  assign ext_wrap = ext_step && ext_nxt[DATA_W] && !wr_ext && !clr;
  assign wrap     = pri_wrap || ext_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_IDLE;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_store(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
    end else if (clr) begin
      pri_q <= '0;
    end else if (wr_pri) begin
      pri_q <= wdata;
    end else if (pri_step) begin
      pri_q <= pri_nxt[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= '0;
    end else if (clr) begin
      ext_q <= '0;
    end else if (wr_ext) begin
      ext_q <= wdata;
    end else if (ext_step) begin
      ext_q <= ext_nxt[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else if (wrap) begin
      stat_q <= 1'b1;
    end else if (wr_stat && wdata[0]) begin
      stat_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b1;
    end else if (wr_mask) begin
      mask_q <= wdata[0];
    end
  end

endmodule

// File: rtl/pcb_bank.sv
module pcb_bank
  import pcb_pkg::*;
#(
  parameter int          NSLOT      = 8,
  parameter int          NEV        = 16,
  parameter logic [31:0] VERSION    = 32'h0000_0031,
  parameter logic [31:0] RANGE_INFO = 32'h00FF_0000,
  parameter logic [31:0] IDENT_INFO = 32'h0002_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NEV-1:0]    pri_inc,
  input  logic [NEV-1:0]    ext_inc,
  input  logic [TGT_W-1:0]  ev_target,
  input  logic [LEN_W-1:0]  ev_len,
  output logic              irq
);

  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  reg_kind_e         kind;
  logic [SLOT_W-1:0] slot;
  logic              glb_q;

  logic [DATA_W-1:0] ctrl_arr [NSLOT];
  logic [DATA_W-1:0] pri_arr  [NSLOT];
  logic [DATA_W-1:0] ext_arr  [NSLOT];
  logic [NSLOT-1:0]  stat_vec;
  logic [NSLOT-1:0]  mask_vec;
  logic [NSLOT-1:0]  slot_en_vec;
  logic [NSLOT-1:0]  pri_step_vec;
  logic [NSLOT-1:0]  ext_step_vec;
  logic [NSLOT-1:0]  wrap_vec;
  logic [NSLOT-1:0]  irq_vec;

  pcb_decode #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_dec (
    .addr (bus_addr),
    .kind (kind),
    .slot (slot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q <= 1'b0;
    end else if (bus_wr && kind == K_GLB) begin
      glb_q <= bus_wdata[0];
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic hit;
    assign hit = bus_wr && (slot == SLOT_W'(i));

    pcb_slot #(.NEV(NEV)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .glb_en    (glb_q),
      .wr_ctrl   (hit && kind == K_CTRL),
      .wr_pri    (hit && kind == K_PRI),
      .wr_ext    (hit && kind == K_EXT),
      .wr_stat   (hit && kind == K_STAT),
      .wr_mask   (hit && kind == K_MASK),
      .wdata     (bus_wdata),
      .pri_inc   (pri_inc),
      .ext_inc   (ext_inc),
      .ev_target (ev_target),
      .ev_len    (ev_len),
      .ctrl_q    (ctrl_arr[i]),
      .pri_q     (pri_arr[i]),
      .ext_q     (ext_arr[i]),
      .stat_q    (stat_vec[i]),
      .mask_q    (mask_vec[i]),
      .slot_en   (slot_en_vec[i]),
      .pri_step  (pri_step_vec[i]),
      .ext_step  (ext_step_vec[i]),
      .wrap      (wrap_vec[i])
    );

    assign irq_vec[i] = stat_vec[i] && !mask_vec[i];
  end

  assign irq = |irq_vec;

  always_comb begin
    unique case (kind)
      K_GLB:   bus_rdata = {{(DATA_W-1){1'b0}}, glb_q};
      K_CTRL:  bus_rdata = ctrl_arr[slot];
      K_PRI:   bus_rdata = pri_arr[slot];
      K_EXT:   bus_rdata = ext_arr[slot];
      K_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, stat_vec[slot]};
      K_MASK:  bus_rdata = {{(DATA_W-1){1'b0}}, mask_vec[slot]};
      K_RANGE: bus_rdata = {32'h0, RANGE_INFO};
      K_VER:   bus_rdata = {32'h0, VERSION};
      K_IDENT: bus_rdata = {32'h0, IDENT_INFO};
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pcb_bank_chk.sv
module pcb_bank_chk
  import pcb_pkg::*;
#(
  parameter int NSLOT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              glb_en,
  input logic [NSLOT-1:0]  slot_en_vec,
  input logic [NSLOT-1:0]  pri_step_vec,
  input logic [NSLOT-1:0]  ext_step_vec,
  input logic [NSLOT-1:0]  wrap_vec,
  input logic [NSLOT-1:0]  stat_vec
);

  localparam logic [ADDR_W:0] GAP_LO = {1'b0, OFF_STAT} + (ADDR_W+1)'(SLOT_STRIDE * NSLOT);
  localparam logic [ADDR_W:0] GAP_HI = {1'b0, OFF_RANGE};

  // R4: the global gate stops every counter
  p_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> (pri_step_vec == '0 && ext_step_vec == '0));

  // R3: only enabled slots advance
  p_slot_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pri_step_vec | ext_step_vec) & ~slot_en_vec) == '0);

  // R9: a wrap leaves the status bit set
  p_wrap_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_vec != '0) |=> ((stat_vec & $past(wrap_vec)) == $past(wrap_vec)));

  // R9: status only rises after a wrap
  p_stat_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vec & ~$past(stat_vec) & ~$past(wrap_vec)) == '0);

  // R10: the interrupt holds until software writes
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !bus_wr) |=> irq);

  // R2: the gap above the per-slot banks reads zero
  p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, bus_addr} >= GAP_LO && {1'b0, bus_addr} < GAP_HI) |-> bus_rdata == '0);

endmodule

bind pcb_bank pcb_bank_chk #(.NSLOT(NSLOT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_rdata    (bus_rdata),
  .irq          (irq),
  .glb_en       (glb_q),
  .slot_en_vec  (slot_en_vec),
  .pri_step_vec (pri_step_vec),
  .ext_step_vec (ext_step_vec),
  .wrap_vec     (wrap_vec),
  .stat_vec     (stat_vec)
);

// File: tb/tb_pcb_bank.sv
module tb_pcb_bank;

  localparam logic [31:0] P_VER   = 32'h0000_0031;
  localparam logic [31:0] P_RANGE = 32'h00FF_0000;
  localparam logic [31:0] P_IDENT = 32'h0002_0001;

  // control word with enable, length mode 3 and event code 5
  localparam logic [63:0] C_BASE = 64'h0000_000C_0010_0005;
  localparam logic [63:0] C_CLR  = 64'h0000_0000_0040_0000;

  typedef struct packed {
    logic [63:0] ctrl;
    logic [15:0] pv;
    logic [15:0] ev;
    logic [16:0] tgt;
    logic [3:0]  len;
    logic [7:0]  n;
    logic [63:0] ep;
    logic [63:0] ee;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{64'h0000_000C_0010_0005, 16'h0020, 16'h0020, 17'h0,   4'd0, 8'd10, 64'd10, 64'd10}, // R3 both
    '{64'h0000_000C_0010_0005, 16'h0020, 16'h0000, 17'h0,   4'd0, 8'd6,  64'd6,  64'd0},  // R3 primary only
    '{64'h0000_000C_0010_0005, 16'h0040, 16'h0020, 17'h0,   4'd0, 8'd5,  64'd0,  64'd5},  // R3 line select
    '{64'h0000_000C_0010_0006, 16'h0020, 16'h0020, 17'h0,   4'd0, 8'd4,  64'd0,  64'd0},  // R3 code mismatch
    '{64'h0000_123D_0010_0005, 16'h0020, 16'h0020, 17'h123, 4'd0, 8'd7,  64'd7,  64'd7},  // R5 match
    '{64'h0000_123D_0010_0005, 16'h0020, 16'h0020, 17'h124, 4'd0, 8'd7,  64'd0,  64'd0},  // R5 miss
    '{64'h0000_000C_4410_0005, 16'h0020, 16'h0020, 17'h0,   4'd4, 8'd5,  64'd5,  64'd5},  // R6 ge pass
    '{64'h0000_000C_4410_0005, 16'h0020, 16'h0020, 17'h0,   4'd3, 8'd5,  64'd0,  64'd0},  // R6 ge fail
    '{64'h0000_000C_4C10_0005, 16'h0020, 16'h0020, 17'h0,   4'd3, 8'd3,  64'd3,  64'd3},  // R6 lt pass
    '{64'h0000_000C_4C10_0005, 16'h0020, 16'h0020, 17'h0,   4'd4, 8'd3,  64'd0,  64'd0},  // R6 lt fail
    '{64'h0000_000C_C410_0005, 16'h0020, 16'h0020, 17'h0,   4'd0, 8'd4,  64'd4,  64'd4},  // R6 over limit
    '{64'h0000_000C_0000_0005, 16'h0020, 16'h0020, 17'h0,   4'd0, 8'd4,  64'd0,  64'd0}   // R3 disabled
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [15:0] pri_inc = '0;
  logic [15:0] ext_inc = '0;
  logic [16:0] ev_target = '0;
  logic [3:0]  ev_len = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [63:0] rv;

  always #4 clk = ~clk;

  pcb_bank #(.NSLOT(8), .NEV(16), .VERSION(P_VER), .RANGE_INFO(P_RANGE),
             .IDENT_INFO(P_IDENT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pri_inc(pri_inc),
    .ext_inc(ext_inc), .ev_target(ev_target), .ev_len(ev_len), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic run(input logic [15:0] pv, input logic [15:0] ev,
                     input logic [16:0] tg, input logic [3:0] ln, input int n);
    @(negedge clk);
    pri_inc = pv; ext_inc = ev; ev_target = tg; ev_len = ln;
    repeat (n) @(negedge clk);
    pri_inc = '0; ext_inc = '0; ev_target = '0; ev_len = '0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h000, rv); chk("R1 global", rv, 64'h0);
    rd(12'h010, rv); chk("R1 ctrl idle", rv, 64'h0000_0004_0000_0000);
    rd(12'h090, rv); chk("R1 primary", rv, 64'h0);
    rd(12'h110, rv); chk("R1 extended", rv, 64'h0);
    rd(12'h154, rv); chk("R1 mask", rv, 64'h1);
    rd(12'h150, rv); chk("R1 status", rv, 64'h0);
    chk("R1 irq", {63'h0, irq}, 64'h0);

    // R2 info and unmapped offsets
    rd(12'hFE4, rv); chk("R2 version", rv, {32'h0, P_VER});
    rd(12'hFE0, rv); chk("R2 range", rv, {32'h0, P_RANGE});
    rd(12'hFE8, rv); chk("R2 ident", rv, {32'h0, P_IDENT});
    rd(12'h0D0, rv); chk("R2 unmapped gap", rv, 64'h0);
    rd(12'h800, rv); chk("R2 unmapped high", rv, 64'h0);

    // table walk on slot 2
    wr(12'h000, 64'h1);
    for (int k = 0; k < NV; k++) begin
      wr(12'h020, TBL[k].ctrl | C_CLR);
      run(TBL[k].pv, TBL[k].ev, TBL[k].tgt, TBL[k].len, int'(TBL[k].n));
      rd(12'h0A0, rv); chk($sformatf("R3/R5/R6 vec%0d primary", k), rv, TBL[k].ep);
      rd(12'h120, rv); chk($sformatf("R3/R5/R6 vec%0d extended", k), rv, TBL[k].ee);
    end

    // R4 global gate
    wr(12'h020, C_BASE | C_CLR);
    wr(12'h000, 64'h0);
    run(16'h0020, 16'h0020, 17'h0, 4'd0, 8);
    rd(12'h0A0, rv); chk("R4 gate primary", rv, 64'h0);
    rd(12'h120, rv); chk("R4 gate extended", rv, 64'h0);
    wr(12'h000, 64'h1);

    // R7 reset bit on slot 3
    wr(12'h0A8, 64'h55);
    wr(12'h128, 64'h66);
    wr(12'h028, C_BASE | C_CLR);
    rd(12'h0A8, rv); chk("R7 primary cleared", rv, 64'h0);
    rd(12'h128, rv); chk("R7 extended cleared", rv, 64'h0);
    rd(12'h028, rv); chk("R7 ctrl readback", rv, C_BASE);

    // R8 preload and write precedence on slot 4
    wr(12'h0B0, 64'h8000_0000_0000_0000);
    wr(12'h030, C_BASE);
    run(16'h0020, 16'h0000, 17'h0, 4'd0, 3);
    rd(12'h0B0, rv); chk("R8 preload count", rv, 64'h8000_0000_0000_0003);
    @(negedge clk);
    pri_inc = 16'h0020;
    wr(12'h0B0, 64'h100);
    @(negedge clk);
    pri_inc = '0;
    rd(12'h0B0, rv); chk("R8 write wins", rv, 64'h101);

    // R9 and R10 on slot 1
    wr(12'h098, 64'hFFFF_FFFF_FFFF_FFFE);
    wr(12'h018, C_BASE);
    run(16'h0020, 16'h0000, 17'h0, 4'd0, 2);
    rd(12'h098, rv); chk("R9 wrapped value", rv, 64'h0);
    rd(12'h158, rv); chk("R9 status set", rv, 64'h1);
    chk("R10 masked irq", {63'h0, irq}, 64'h0);
    wr(12'h15C, 64'h0);
    rd(12'h158, rv);
    chk("R10 unmasked irq", {63'h0, irq}, 64'h1);
    wr(12'h158, 64'h0);
    rd(12'h158, rv); chk("R9 write zero keeps", rv, 64'h1);
    chk("R10 irq held", {63'h0, irq}, 64'h1);
    wr(12'h158, 64'h1);
    rd(12'h158, rv); chk("R9 cleared", rv, 64'h0);
    chk("R10 irq low", {63'h0, irq}, 64'h0);
    wr(12'h118, 64'hFFFF_FFFF_FFFF_FFFF);
    run(16'h0000, 16'h0020, 17'h0, 4'd0, 1);
    rd(12'h158, rv); chk("R9 extended wrap", rv, 64'h1);
    chk("R10 extended irq", {63'h0, irq}, 64'h1);
    wr(12'h158, 64'h1);
    rd(12'h158, rv);
    chk("R10 irq after clear", {63'h0, irq}, 64'h0);

    // R2 slot stride
    wr(12'h0C8, 64'hABCD);
    rd(12'h0C8, rv); chk("R2 slot7 primary", rv, 64'hABCD);
    rd(12'h0C0, rv); chk("R2 slot6 primary", rv, 64'h0);
    rd(12'h148, rv); chk("R2 slot7 extended", rv, 64'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule